// File: doc/BRIEF.md
# Region-Based Sharing-Partner Predictor

This block sits beside a core's cache controller in a directory-coherent multicore. It remembers, for each 1 KB memory region, which remote core last supplied data for that region. When the cache misses, the block looks up the region of the miss address. If it finds a prediction, it issues a request straight to the predicted peer cache. In the same cycle it sends the home directory a notification, so the directory remains the single point that orders all requests. When there is no prediction, only the ordinary directory request goes out.

Each table entry keeps two partners: the most recent responder and the one before it. The older partner is offered as a secondary hint. The table learns from two sources. One is data responses, which carry the responding core. The other is directory corrections, which name the true owner after a wrong guess.

Top module: `region_sharer_pred`

## Requirements
- R1: After reset every table entry is invalid and all request outputs are low, so the first lookup of any region predicts nothing.
- R2: Each cycle with `miss_valid` high produces `dir_req_valid` high exactly one clock later, with `dir_req_addr` equal to the miss address. In a cycle without a miss, `dir_req_valid` is low.
- R3: The address splits into three fields: offset in bits [9:0], table index in bits [15:10] and region tag in bits [31:16]. A lookup hits when the indexed entry is valid and its tag matches. On a hit, `peer_req_valid` and `dir_req_notify` are both 1 and `peer_req_core` is the most recent partner. On a miss, both flags are 0.
- R4: Two addresses that differ only in bits [9:0] get the same prediction. A region with the same index but another tag does not hit, and training it replaces the previous region in that slot.
- R5: A data response from core c trains its region. If the entry already holds that region with a different recent partner, c becomes the recent partner and the old one becomes the secondary partner (`alt_valid`, `alt_core`). If the entry held another region or nothing, the entry is rewritten with c as recent and no secondary partner.
- R6: A response or correction naming the block's own core (`SELF_ID`, default 0) is ignored and leaves the entry unchanged.
- R7: A directory correction (`fix_valid`) retrains its region to the named owner, using the same update as R5. When a correction and a response are both accepted in one cycle, only the correction is applied.
- R8: When a training write and a lookup address the same entry in the same cycle, the lookup result reflects the entry as written in that cycle.
- R9: A response from the core that is already the recent partner leaves both partners unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_addr | input | 32 | Miss address |
| resp_valid | input | 1 | Data response received |
| resp_addr | input | 32 | Address of the data response |
| resp_core | input | 4 | Core that supplied the data |
| fix_valid | input | 1 | Directory correction after a wrong prediction |
| fix_addr | input | 32 | Address of the correction |
| fix_core | input | 4 | True owner named by the directory |
| dir_req_valid | output | 1 | Request or notification to the home directory |
| dir_req_addr | output | 32 | Address carried by the directory and peer requests |
| dir_req_notify | output | 1 | 1: the directory message is a notification that runs alongside a peer request |
| peer_req_valid | output | 1 | Direct request to a predicted peer cache |
| peer_req_core | output | 4 | Predicted peer (most recent partner) |
| alt_valid | output | 1 | Secondary partner available |
| alt_core | output | 4 | Secondary partner |

## Verification
Two pairs of functions can land in the same cycle. A training write can coincide with a lookup of the same entry. A correction can coincide with a response. The bench provokes the first by driving a response and a miss to one region together. It then requires the registered prediction to already show the new partner, or to show the partners unchanged when the response is a self response or a repeat. For the second, it drives a correction and a response to one region in one cycle and confirms on a later lookup that only the corrected owner was recorded, with the earlier partner shifted into the secondary slot.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_ADDR_W   = 32;
  localparam int SP_REGION_W = 10;
  localparam int SP_ENTRIES  = 64;
  localparam int SP_CORE_W   = 4;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RESP = 2'd1,
    SRC_FIX  = 2'd2
  } train_src_e;
endpackage

// File: rtl/sp_table.sv
module sp_table #(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 16,
  parameter int CORE_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_vld,
  output logic [TAG_W-1:0]  a_tag,
  output logic [CORE_W-1:0] a_rec,
  output logic              a_pv,
  output logic [CORE_W-1:0] a_prv,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_vld,
  output logic [TAG_W-1:0]  b_tag,
  output logic [CORE_W-1:0] b_rec,
  output logic              b_pv,
  output logic [CORE_W-1:0] b_prv,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [CORE_W-1:0] wr_rec,
  input  logic              wr_pv,
  input  logic [CORE_W-1:0] wr_prv
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] pv_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [CORE_W-1:0]  rec_q [ENTRIES];
  logic [CORE_W-1:0]  prv_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        pv_q[i]  <= 1'b0;
      end else if (sel) begin
        vld_q[i] <= 1'b1;
        pv_q[i]  <= wr_pv;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[i] <= wr_tag;
        rec_q[i] <= wr_rec;
        prv_q[i] <= wr_prv;
      end
    end
  end

  always_comb begin
    a_vld = vld_q[a_idx];
    a_tag = tag_q[a_idx];
    a_rec = rec_q[a_idx];
    a_pv  = pv_q[a_idx];
    a_prv = prv_q[a_idx];
    b_vld = vld_q[b_idx];
    b_tag = tag_q[b_idx];
    b_rec = rec_q[b_idx];
    b_pv  = pv_q[b_idx];
    b_prv = prv_q[b_idx];
  end

  // R5: a written slot reads back valid with the stored tag
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/sp_train.sv
module sp_train
  import sp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 10,
  parameter int IDX_W    = 6,
  parameter int CORE_W   = 4,
  parameter logic [CORE_W-1:0] SELF_ID = '0,
  localparam int TAG_W   = ADDR_W - REGION_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resp_valid,
  input  logic [ADDR_W-1:0] resp_addr,
  input  logic [CORE_W-1:0] resp_core,
  input  logic              fix_valid,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [CORE_W-1:0] fix_core,
  output logic [IDX_W-1:0]  b_idx,
  input  logic              b_vld,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [CORE_W-1:0] b_rec,
  input  logic              b_pv,
  input  logic [CORE_W-1:0] b_prv,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [CORE_W-1:0] wr_rec,
  output logic              wr_pv,
  output logic [CORE_W-1:0] wr_prv
);
  train_src_e        src;
  logic [ADDR_W-1:0] sel_addr;
  logic [CORE_W-1:0] sel_core;
  logic              same_region;
  logic              unused_lo;

  assign unused_lo = ^{resp_addr[REGION_W-1:0], fix_addr[REGION_W-1:0]};

  // source choice: correction before response, own-core reports dropped
  always_comb begin
    if (fix_valid && fix_core != SELF_ID)        src = SRC_FIX;
    else if (resp_valid && resp_core != SELF_ID) src = SRC_RESP;
    else                                         src = SRC_NONE;
    sel_addr = (src == SRC_FIX) ? fix_addr : resp_addr;
    sel_core = (src == SRC_FIX) ? fix_core : resp_core;
  end

  assign b_idx       = sel_addr[REGION_W +: IDX_W];
  assign same_region = b_vld && (b_tag == sel_addr[ADDR_W-1 -: TAG_W]);

  always_comb begin
    wr_en  = (src != SRC_NONE);
    wr_idx = b_idx;
    wr_tag = sel_addr[ADDR_W-1 -: TAG_W];
    wr_rec = sel_core;
    wr_pv  = 1'b0;
    wr_prv = '0;
    if (same_region) begin
      if (b_rec == sel_core) begin
        wr_pv  = b_pv;
        wr_prv = b_prv;
      end else begin
        wr_pv  = 1'b1;
        wr_prv = b_rec;
      end
    end
  end

  // R6: nothing naming the own core is ever written as a partner
  a_r6_no_self_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_rec != SELF_ID));
  // R9: repeat partner on a resident region keeps the secondary slot
  a_r9_repeat_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && same_region && b_rec == wr_rec) |-> (wr_pv == b_pv && wr_prv == b_prv));
  // R7: an accepted correction always drives the written owner
  a_r7_fix_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_valid && fix_core != SELF_ID) |-> (wr_en && wr_rec == fix_core));
endmodule

// File: rtl/sp_lookup.sv
module sp_lookup #(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 10,
  parameter int IDX_W    = 6,
  parameter int CORE_W   = 4,
  parameter logic [CORE_W-1:0] SELF_ID = '0,
  localparam int TAG_W   = ADDR_W - REGION_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic [IDX_W-1:0]  a_idx,
  input  logic              a_vld,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [CORE_W-1:0] a_rec,
  input  logic              a_pv,
  input  logic [CORE_W-1:0] a_prv,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [CORE_W-1:0] wr_rec,
  input  logic              wr_pv,
  input  logic [CORE_W-1:0] wr_prv,
  output logic              dir_req_valid,
  output logic [ADDR_W-1:0] dir_req_addr,
  output logic              dir_req_notify,
  output logic              peer_req_valid,
  output logic [CORE_W-1:0] peer_req_core,
  output logic              alt_valid,
  output logic [CORE_W-1:0] alt_core
);
  logic              fwd;
  logic              e_vld, e_pv;
  logic [TAG_W-1:0]  e_tag;
  logic [CORE_W-1:0] e_rec, e_prv;
  logic              hit;
  logic              dir_d, peer_d, alt_d;

  assign a_idx = miss_addr[REGION_W +: IDX_W];
  assign fwd   = wr_en && (wr_idx == a_idx);

  // same-cycle training to the looked-up slot is seen by the lookup
  always_comb begin
    e_vld = fwd ? 1'b1   : a_vld;
    e_tag = fwd ? wr_tag : a_tag;
    e_rec = fwd ? wr_rec : a_rec;
    e_pv  = fwd ? wr_pv  : a_pv;
    e_prv = fwd ? wr_prv : a_prv;
    hit   = e_vld && (e_tag == miss_addr[ADDR_W-1 -: TAG_W]);
    dir_d  = miss_valid;
    peer_d = miss_valid && hit;
    alt_d  = miss_valid && hit && e_pv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_req_valid  <= 1'b0;
      dir_req_notify <= 1'b0;
      peer_req_valid <= 1'b0;
      alt_valid      <= 1'b0;
    end else begin
      dir_req_valid  <= dir_d;
      dir_req_notify <= peer_d;
      peer_req_valid <= peer_d;
      alt_valid      <= alt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_req_addr  <= '0;
      peer_req_core <= '0;
      alt_core      <= '0;
    end else if (miss_valid) begin
      dir_req_addr  <= miss_addr;
      peer_req_core <= e_rec;
      alt_core      <= e_prv;
    end
  end

  // R2: directory message one cycle after every miss, never otherwise
  a_r2_dir_follows_miss: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dir_req_valid == $past(miss_valid)));
  a_r2_dir_addr: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (dir_req_addr == $past(miss_addr)));
  // R3: a peer request is always paired with the directory notification
  a_r3_peer_with_dir: assert property (@(posedge clk) disable iff (!rst_n)
    peer_req_valid |-> (dir_req_valid && dir_req_notify));
  // R6: own core is never predicted
  a_r6_peer_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    peer_req_valid |-> (peer_req_core != SELF_ID));
  // R5: secondary hint only with a primary, and it differs from it
  a_r5_alt_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    alt_valid |-> (peer_req_valid && alt_core != peer_req_core));
endmodule

// File: rtl/region_sharer_pred.sv
module region_sharer_pred
  import sp_pkg::*;
#(
  parameter int ADDR_W   = SP_ADDR_W,
  parameter int REGION_W = SP_REGION_W,
  parameter int ENTRIES  = SP_ENTRIES,
  parameter int CORE_W   = SP_CORE_W,
  parameter logic [CORE_W-1:0] SELF_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              resp_valid,
  input  logic [ADDR_W-1:0] resp_addr,
  input  logic [CORE_W-1:0] resp_core,
  input  logic              fix_valid,
  input  logic [ADDR_W-1:0] fix_addr,
  input  logic [CORE_W-1:0] fix_core,
  output logic              dir_req_valid,
  output logic [ADDR_W-1:0] dir_req_addr,
  output logic              dir_req_notify,
  output logic              peer_req_valid,
  output logic [CORE_W-1:0] peer_req_core,
  output logic              alt_valid,
  output logic [CORE_W-1:0] alt_core
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - REGION_W - IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
  logic              a_vld, a_pv, b_vld, b_pv, wr_en, wr_pv;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [CORE_W-1:0] a_rec, a_prv, b_rec, b_prv, wr_rec, wr_prv;

  sp_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CORE_W(CORE_W)) u_tab (
    .clk(clk), .rst_n(rst_int_n),
    .a_idx(a_idx), .a_vld(a_vld), .a_tag(a_tag), .a_rec(a_rec), .a_pv(a_pv), .a_prv(a_prv),
    .b_idx(b_idx), .b_vld(b_vld), .b_tag(b_tag), .b_rec(b_rec), .b_pv(b_pv), .b_prv(b_prv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_rec(wr_rec),
    .wr_pv(wr_pv), .wr_prv(wr_prv)
  );

  sp_train #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .IDX_W(IDX_W),
             .CORE_W(CORE_W), .SELF_ID(SELF_ID)) u_trn (
    .clk(clk), .rst_n(rst_int_n),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_core(resp_core),
    .fix_valid(fix_valid), .fix_addr(fix_addr), .fix_core(fix_core),
    .b_idx(b_idx), .b_vld(b_vld), .b_tag(b_tag), .b_rec(b_rec), .b_pv(b_pv), .b_prv(b_prv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_rec(wr_rec),
    .wr_pv(wr_pv), .wr_prv(wr_prv)
  );

  sp_lookup #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .IDX_W(IDX_W),
              .CORE_W(CORE_W), .SELF_ID(SELF_ID)) u_lkp (
    .clk(clk), .rst_n(rst_int_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .a_idx(a_idx), .a_vld(a_vld), .a_tag(a_tag), .a_rec(a_rec), .a_pv(a_pv), .a_prv(a_prv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_rec(wr_rec),
    .wr_pv(wr_pv), .wr_prv(wr_prv),
    .dir_req_valid(dir_req_valid), .dir_req_addr(dir_req_addr),
    .dir_req_notify(dir_req_notify), .peer_req_valid(peer_req_valid),
    .peer_req_core(peer_req_core), .alt_valid(alt_valid), .alt_core(alt_core)
  );

  // R1: outputs idle while the internal reset is held
  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!dir_req_valid && !peer_req_valid && !alt_valid));
endmodule

// File: tb/sim_region_sharer_pred.sv
module sim_region_sharer_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0, resp_valid = 1'b0, fix_valid = 1'b0;
  logic [31:0] miss_addr = '0, resp_addr = '0, fix_addr = '0;
  logic [3:0]  resp_core = '0, fix_core = '0;
  logic        dir_req_valid, dir_req_notify, peer_req_valid, alt_valid;
  logic [31:0] dir_req_addr;
  logic [3:0]  peer_req_core, alt_core;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  region_sharer_pred u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_core(resp_core),
    .fix_valid(fix_valid), .fix_addr(fix_addr), .fix_core(fix_core),
    .dir_req_valid(dir_req_valid), .dir_req_addr(dir_req_addr),
    .dir_req_notify(dir_req_notify), .peer_req_valid(peer_req_valid),
    .peer_req_core(peer_req_core), .alt_valid(alt_valid), .alt_core(alt_core)
  );

  // tag in [31:16], index in [15:10], offset in [9:0]
  localparam logic [31:0] RA  = 32'h0001_0C00;  // tag 1, index 3
  localparam logic [31:0] RA2 = 32'h0001_0FFF;  // same region, last byte
  localparam logic [31:0] RB  = 32'h0002_0C00;  // tag 2, index 3
  localparam logic [31:0] RC  = 32'h0001_1000;  // tag 1, index 4

  typedef struct packed {
    logic mv; logic [31:0] ma;
    logic rv; logic [31:0] ra; logic [3:0] rc;
    logic fv; logic [31:0] fa; logic [3:0] fc;
    logic ep; logic [3:0] ec; logic ea; logic [3:0] eac;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, RA,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R1 empty table
    '{1'b0, 32'h0, 1'b1, RA, 4'd5, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R5 train 5
    '{1'b1, RA2, 1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b1, 4'd5,  1'b0, 4'd0}, // R3 R4 offset
    '{1'b0, 32'h0, 1'b1, RA, 4'd7, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R5 train 7
    '{1'b1, RA,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b1, 4'd7,  1'b1, 4'd5}, // R5 shift
    '{1'b1, RA,  1'b1, RA, 4'd7, 1'b0, 32'h0, 4'd0,    1'b1, 4'd7,  1'b1, 4'd5}, // R9 R8 repeat
    '{1'b1, RA,  1'b1, RA, 4'd0, 1'b0, 32'h0, 4'd0,    1'b1, 4'd7,  1'b1, 4'd5}, // R6 self
    '{1'b1, RC,  1'b1, RC, 4'd9, 1'b0, 32'h0, 4'd0,    1'b1, 4'd9,  1'b0, 4'd0}, // R8 forward
    '{1'b1, RB,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R4 tag miss
    '{1'b0, 32'h0, 1'b1, RB, 4'd2, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R4 replace
    '{1'b1, RA,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0}, // R4 evicted
    '{1'b0, 32'h0, 1'b1, RB, 4'd4, 1'b1, RB, 4'd11,    1'b0, 4'd0,  1'b0, 4'd0}, // R7 both
    '{1'b1, RB,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b1, 4'd11, 1'b1, 4'd2}, // R7 fix won
    '{1'b0, 32'h0, 1'b0, 32'h0, 4'd0, 1'b1, RC, 4'd3,  1'b0, 4'd0,  1'b0, 4'd0}, // R7 fix only
    '{1'b1, RC,  1'b0, 32'h0, 4'd0, 1'b0, 32'h0, 4'd0,  1'b1, 4'd3,  1'b1, 4'd9}  // R7 retrained
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  task automatic drive(input vec_t v);
    miss_valid = v.mv; miss_addr = v.ma;
    resp_valid = v.rv; resp_addr = v.ra; resp_core = v.rc;
    fix_valid  = v.fv; fix_addr  = v.fa; fix_core  = v.fc;
  endtask

  task automatic judge(input vec_t v, input int n);
    chk($sformatf("R2 dir valid v%0d", n), 32'(dir_req_valid), 32'(v.mv));
    chk($sformatf("R3 peer valid v%0d", n), 32'(peer_req_valid), 32'(v.ep));
    chk($sformatf("R3 notify v%0d", n), 32'(dir_req_notify), 32'(v.ep));
    if (v.mv) chk($sformatf("R2 dir addr v%0d", n), dir_req_addr, v.ma);
    if (v.ep) begin
      chk($sformatf("R5 peer core v%0d", n), 32'(peer_req_core), 32'(v.ec));
      chk($sformatf("R5 alt valid v%0d", n), 32'(alt_valid), 32'(v.ea));
      if (v.ea) chk($sformatf("R5 alt core v%0d", n), 32'(alt_core), 32'(v.eac));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while held in reset
    chk("R1 reset dir", 32'(dir_req_valid), 32'd0);
    chk("R1 reset peer", 32'(peer_req_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk);
      #2;
      judge(VEC[i], i);
      @(negedge clk);
    end
    drive('0);

    // R1: mid-run reset clears the table
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 async clear dir", 32'(dir_req_valid), 32'd0);
    chk("R1 async clear alt", 32'(alt_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    miss_valid = 1'b1; miss_addr = RC;
    @(posedge clk); #2;
    chk("R1 table empty after reset", 32'(peer_req_valid), 32'd0);
    chk("R2 dir after reset", 32'(dir_req_valid), 32'd1);

    // R2: no miss, no directory message
    @(negedge clk);
    miss_valid = 1'b0;
    @(posedge clk); #2;
    chk("R2 idle", 32'(dir_req_valid), 32'd0);

    // R6: correction naming own core is ignored
    @(negedge clk);
    fix_valid = 1'b1; fix_addr = RC; fix_core = 4'd0;
    @(negedge clk);
    fix_valid = 1'b0;
    miss_valid = 1'b1; miss_addr = RC;
    @(posedge clk); #2;
    chk("R6 self fix ignored", 32'(peer_req_valid), 32'd0);
    @(negedge clk);
    miss_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule